// File: doc/BRIEF.md
# Dual-Slot Receive Buffer with Destination Filter

This block is the receive half of a small Ethernet MAC. Frame octets come in as a stream with start and end markers. Each frame is checked against its destination address. A frame that passes is packed into 32-bit words and written into one of two receive slots. The slots take turns when alternation is enabled. Each slot has a 2 KiB address window, and the top two words of that window are reserved. Each slot also has a control word. Bit 0 of that word is the occupied flag and bit 3 is the per-slot interrupt enable.

Software reads the stored frame over a simple word-addressed host port. No frame length is recorded, so it reads the whole data area. It then writes the control word to clear the occupied flag and hand the slot back to the receiver.

A frame that passes the filter but finds its slot still occupied is discarded. A saturating counter records each such loss. The station address comes in as an input from the transmit-side registers.

Top module: `rxb_pingpong_rx`

## Requirements
- R1: After reset, both control words and the loss counter read 0, `irq_pulse` is low, and the first frame goes to slot 0.
- R2: A frame whose first octet has bit 0 set (group address) passes the filter, whatever the station address is.
- R3: A frame whose first octet has bit 0 clear passes only if its first six octets equal `station_addr`, compared octet by octet with `station_addr[47:40]` first. Any other frame, including one shorter than six octets, leaves both control words, the loss counter and `irq_pulse` untouched.
- R4: Frame octets are stored from word 0 of the slot upward, four per word. The earliest octet goes in bits 31:24. A final partial word has its unused low octets set to zero.
- R5: When a passing frame's end octet is taken into a free slot, bit 0 of that slot's control word reads 1 from the next read onward.
- R6: `irq_pulse` is high for exactly the one cycle after the end octet of a stored frame, and only if that slot's control bit 3 and `irq_global_en` were both 1. It is low at all other times.
- R7: With `PINGPONG`=1, the target slot alternates after each stored frame. With `PINGPONG`=0, every frame targets slot 0.
- R8: A passing frame whose target slot is occupied when its start octet arrives is not written. The slot's contents and flags stay as they were, the target slot does not change, and the loss counter increments.
- R9: A host write to a control word (byte offset 0x17FC for slot 0, 0x1FFC for slot 1) stores all 32 bits. Writing bit 0 as 0 frees the slot. A commit in the same cycle wins for bit 0.
- R10: Octets beyond the data area (words 0 to 509, i.e. 2040 octets) are discarded. The frame is still marked stored.
- R11: The loss counter reads at byte offset 0x17F8 in bits 7:0 and stops at 255.
- R12: Reads return data one cycle after the address is presented. Slot 0 starts at byte offset 0x1000 and slot 1 at 0x1800. Addresses below 0x1000, unaligned addresses and offset 0x1FF8 read 0. Host writes to the data area have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | An octet is present on rx_data |
| rx_sop | input | 1 | Octet is the first of a frame |
| rx_eop | input | 1 | Octet is the last of a frame |
| rx_data | input | 8 | Frame octet |
| station_addr | input | 48 | Own address, first octet in bits 47:40 |
| irq_global_en | input | 1 | Master interrupt enable |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 13 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the address |
| irq_pulse | output | 1 | One-cycle interrupt after a stored frame |

## Verification
The hardest case to reach from the ports is a saturated loss counter. It needs both slots occupied and then hundreds of passing frames. The bench gets there by setting both occupied flags through direct host writes. It then sends a run of one-octet group frames, which never reach the data area. Truncation is reached with a single group frame longer than the data area, followed by a read of the whole slot. A second instance with alternation disabled receives the same stream. It shows that slot 0 is reused once it has been freed.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int OCTET_W   = 8;
    localparam int WORD_W    = 32;
    localparam int MAC_OCTS  = 6;
    localparam int BIT_FULL  = 0;
    localparam int BIT_IE    = 3;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_DATA,
        RG_LOST,
        RG_CTRL
    } region_e;

    // octet number pos of a MAC address, octet 0 in the top bits
    function automatic logic [OCTET_W-1:0] mac_octet(input logic [8*MAC_OCTS-1:0] mac,
                                                     input logic [2:0] pos);
        logic [OCTET_W-1:0] r;
        r = '0;
        for (int k = 0; k < MAC_OCTS; k++)
            if (pos == 3'(k)) r = mac[8*MAC_OCTS-1-8*k -: OCTET_W];
        return r;
    endfunction
endpackage

// File: rtl/rxb_addr_filter.sv
module rxb_addr_filter
    import rxb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  octet_en,
    input  logic                  first,
    input  logic [OCTET_W-1:0]    octet,
    input  logic [8*MAC_OCTS-1:0] station,
    output logic                  pass
);
    logic [2:0] seen_q, seen_n, pos;
    logic       eq_q, eq_n, grp_q, grp_n;

    always_comb begin
        pos    = first ? 3'd0 : seen_q;
        grp_n  = first ? octet[0] : grp_q;
        eq_n   = (first | eq_q) &
                 ((pos >= 3'(MAC_OCTS)) | (octet == mac_octet(station, pos)));
        seen_n = (pos < 3'(MAC_OCTS)) ? pos + 3'd1 : pos;
        pass   = grp_n | (eq_n & (seen_n == 3'(MAC_OCTS)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            eq_q   <= 1'b0;
            grp_q  <= 1'b0;
        end else if (octet_en) begin
            seen_q <= seen_n;
            eq_q   <= eq_n;
            grp_q  <= grp_n;
        end
    end

    // R2
    grp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (octet_en && !first && grp_q) |-> pass);
endmodule

// File: rtl/rxb_word_packer.sv
module rxb_word_packer
    import rxb_pkg::*;
#(
    parameter int DATA_WORDS = 510,
    parameter int IDX_W      = 9
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               octet_en,
    input  logic               first,
    input  logic               last,
    input  logic [OCTET_W-1:0] octet,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [WORD_W-1:0]  wr_word
);
    logic [1:0]        lane_q, lane;
    logic [IDX_W-1:0]  widx_q, widx;
    logic [WORD_W-1:0] acc_q, base;
    logic [4:0]        shamt;
    logic              room;

    always_comb begin
        lane    = first ? 2'd0 : lane_q;
        widx    = first ? '0 : widx_q;
        base    = (lane == 2'd0) ? '0 : acc_q;
        shamt   = {~lane, 3'b000};
        wr_word = base | ({{(WORD_W-OCTET_W){1'b0}}, octet} << shamt);
        room    = widx < IDX_W'(DATA_WORDS);
        wr_en   = octet_en & ((lane == 2'd3) | last) & room;
        wr_idx  = widx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
            widx_q <= '0;
            acc_q  <= '0;
        end else if (octet_en) begin
            acc_q  <= wr_word;
            lane_q <= lane + 2'd1;
            widx_q <= ((lane == 2'd3) && room) ? widx + IDX_W'(1) : widx;
        end
    end

    // R10
    idx_in_area_chk: assert property (@(posedge clk) disable iff (rst)
        (octet_en && !first) |-> (widx_q <= IDX_W'(DATA_WORDS)));
endmodule

// File: rtl/rxb_pingpong_rx.sv
module rxb_pingpong_rx
    import rxb_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter bit PINGPONG  = 1'b1,
    parameter int LOST_W    = 8
)(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rx_valid,
    input  logic                          rx_sop,
    input  logic                          rx_eop,
    input  logic [7:0]                    rx_data,
    input  logic [47:0]                   station_addr,
    input  logic                          irq_global_en,
    input  logic                          host_we,
    input  logic [$clog2(BUF_BYTES)+1:0]  host_addr,
    input  logic [31:0]                   host_wdata,
    output logic [31:0]                   host_rdata,
    output logic                          irq_pulse
);
    localparam int BUF_WORDS  = BUF_BYTES / 4;
    localparam int IDX_W      = $clog2(BUF_WORDS);
    localparam int DATA_WORDS = BUF_WORDS - 2;
    localparam int ADDR_W     = $clog2(BUF_BYTES) + 2;

    logic [WORD_W-1:0] mem [2*BUF_WORDS];
    logic [WORD_W-1:0] ctrl_q [2];
    logic              in_frame_q, tgt_q, drop_q, active_q, irq_q;
    logic [LOST_W-1:0] lost_q;
    logic [WORD_W-1:0] rdata_q;

    logic              byte_en, tgt, drop, pass, commit, lose;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_word;

    logic              hsel;
    logic [IDX_W-1:0]  hword;
    region_e           region;

    always_comb begin
        byte_en = rx_valid & (rx_sop | in_frame_q);
        tgt     = rx_sop ? active_q : tgt_q;
        drop    = rx_sop ? ctrl_q[active_q][BIT_FULL] : drop_q;
        commit  = byte_en & rx_eop & pass & ~drop;
        lose    = byte_en & rx_eop & pass & drop;
    end

    rxb_addr_filter u_filter (
        .clk      (clk),
        .rst      (rst),
        .octet_en (byte_en),
        .first    (rx_sop),
        .octet    (rx_data),
        .station  (station_addr),
        .pass     (pass)
    );

    rxb_word_packer #(.DATA_WORDS(DATA_WORDS), .IDX_W(IDX_W)) u_packer (
        .clk      (clk),
        .rst      (rst),
        .octet_en (byte_en),
        .first    (rx_sop),
        .last     (rx_eop),
        .octet    (rx_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_word  (wr_word)
    );

    // host address decode
    always_comb begin
        hsel  = host_addr[ADDR_W-2];
        hword = host_addr[ADDR_W-3:2];
        if (!host_addr[ADDR_W-1] || (host_addr[1:0] != 2'b00))
            region = RG_NONE;
        else if (hword == IDX_W'(BUF_WORDS-1))
            region = RG_CTRL;
        else if (hword == IDX_W'(BUF_WORDS-2))
            region = hsel ? RG_NONE : RG_LOST;
        else
            region = RG_DATA;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !drop)
            mem[{tgt, wr_idx}] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            tgt_q      <= 1'b0;
            drop_q     <= 1'b0;
            active_q   <= 1'b0;
            lost_q     <= '0;
            irq_q      <= 1'b0;
            for (int b = 0; b < 2; b++) ctrl_q[b] <= '0;
        end else begin
            if (byte_en) begin
                in_frame_q <= ~rx_eop;
                tgt_q      <= tgt;
                drop_q     <= drop;
            end
            for (int b = 0; b < 2; b++) begin
                if (host_we && region == RG_CTRL && hsel == 1'(b))
                    ctrl_q[b] <= host_wdata;
                if (commit && tgt == 1'(b))
                    ctrl_q[b][BIT_FULL] <= 1'b1;
            end
            if (commit && PINGPONG)
                active_q <= ~active_q;
            if (lose && lost_q != '1)
                lost_q <= lost_q + LOST_W'(1);
            irq_q <= commit & ctrl_q[tgt][BIT_IE] & irq_global_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            case (region)
                RG_DATA: rdata_q <= mem[{hsel, hword}];
                RG_LOST: rdata_q <= WORD_W'(lost_q);
                RG_CTRL: rdata_q <= ctrl_q[hsel];
                default: rdata_q <= '0;
            endcase
        end
    end

    assign host_rdata = rdata_q;
    assign irq_pulse  = irq_q;

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(rx_valid && rx_eop && irq_global_en));

    // R5
    full_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q[0][BIT_FULL]) |->
            ($past(commit && !tgt) || $past(host_we && region == RG_CTRL && !hsel)));

    // R7
    act_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q != $past(active_q)) |-> $past(commit));

    // R11
    lost_mono_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lost_q >= $past(lost_q)));

    // R8
    lost_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (lost_q != $past(lost_q)) |-> $past(rx_valid && rx_eop));
endmodule

// File: tb/rxb_pingpong_rx_tb.sv
module rxb_pingpong_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [47:0] station_addr = 48'h02_11_22_33_44_55;
    logic        irq_global_en = 1'b0;
    logic        host_we = 1'b0;
    logic [12:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata, np_rdata;
    logic        irq_pulse, np_irq;

    always #2.5 clk = ~clk;

    rxb_pingpong_rx dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
        .rx_data(rx_data), .station_addr(station_addr), .irq_global_en(irq_global_en),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_pulse(irq_pulse));

    rxb_pingpong_rx #(.PINGPONG(1'b0)) dut_np (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
        .rx_data(rx_data), .station_addr(station_addr), .irq_global_en(irq_global_en),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(np_rdata), .irq_pulse(np_irq));

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    bit   m_full[2], m_ie[2], m_act, np_full0;
    int   m_lost;
    bit   exp_irq = 1'b0;
    byte  img0[$], img1[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && !finished)
            check(irq_pulse === exp_irq, "R6 irq", 32'(irq_pulse), 32'(exp_irq));
        exp_irq = 1'b0;
    end

    task automatic rd(input int a, output logic [31:0] d, output logic [31:0] dn);
        @(negedge clk);
        host_addr = 13'(a);
        @(posedge clk);
        #1;
        d  = host_rdata;
        dn = np_rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 13'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        if (a == 'h17FC) begin m_full[0] = d[0]; m_ie[0] = d[3]; np_full0 = d[0]; end
        if (a == 'h1FFC) begin m_full[1] = d[0]; m_ie[1] = d[3]; end
    endtask

    task automatic send(input byte f[$]);
        bit t, dr, ps, uni;
        t  = m_act;
        dr = m_full[t];
        uni = (f.size() >= 6);
        for (int k = 0; k < 6 && k < f.size(); k++)
            if (f[k] != station_addr[47-8*k -: 8]) uni = 1'b0;
        ps = f[0][0] | uni;
        for (int i = 0; i < f.size(); i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sop = (i == 0); rx_eop = (i == f.size()-1); rx_data = f[i];
            if (i == f.size()-1 && ps && !dr && m_ie[t] && irq_global_en) exp_irq = 1'b1;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
        if (ps) begin
            if (dr) begin
                if (m_lost < 255) m_lost++;
            end else begin
                m_full[t] = 1'b1;
                if (t) img1 = f; else img0 = f;
                m_act = ~m_act;
            end
            if (!np_full0) np_full0 = 1'b1;
        end
    endtask

    task automatic check_slot(input bit b, input byte f[$], input string req);
        int n;
        logic [31:0] d, dn, e;
        n = (f.size() > 2040) ? 2040 : f.size();
        for (int w = 0; w < (n+3)/4; w++) begin
            e = '0;
            for (int k = 0; k < 4; k++)
                if (4*w+k < n) e[31-8*k -: 8] = f[4*w+k];
            rd('h1000 + (b ? 'h800 : 0) + 4*w, d, dn);
            check(d === e, req, d, e);
        end
    endtask

    task automatic check_ctrl(input string req);
        logic [31:0] d, dn, e;
        for (int b = 0; b < 2; b++) begin
            rd(b ? 'h1FFC : 'h17FC, d, dn);
            e = {28'd0, m_ie[b], 2'b00, m_full[b]};
            check(d === e, req, d, e);
        end
    endtask

    task automatic check_lost(input string req);
        logic [31:0] d, dn;
        rd('h17F8, d, dn);
        check(d === 32'(m_lost), req, d, 32'(m_lost));
    endtask

    function automatic void mk_uni(output byte f[$], input int n, input int seed);
        f = {};
        for (int k = 0; k < n; k++)
            f.push_back(k < 6 ? byte'(station_addr[47-8*k -: 8]) : byte'(k*7 + seed));
    endfunction

    function automatic void mk_grp(output byte f[$], input int n, input int seed);
        f = {};
        for (int k = 0; k < n; k++)
            f.push_back(k == 0 ? 8'h33 : byte'(k*3 + seed));
    endfunction

    task automatic finish_run();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        byte fa[$], fb[$], fc[$], fx[$];
        logic [31:0] d, dn;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_ctrl("R1 ctrl reset");
        check_lost("R1 lost reset");

        irq_global_en = 1'b1;
        wr('h17FC, 32'h8);
        wr('h1FFC, 32'h8);
        check_ctrl("R9 ie write");

        // R3/R4/R5: unicast frame to slot 0
        mk_uni(fa, 64, 1);
        send(fa);
        check_ctrl("R5 slot0 stored");
        check_slot(0, fa, "R4 slot0 data");
        rd('h17FC, d, dn);
        check(dn[0] === 1'b1, "R7 np slot0 full", dn, 32'h1);

        // R2/R7: group frame with partial word to slot 1
        mk_grp(fb, 13, 5);
        send(fb);
        check_ctrl("R7 slot1 stored");
        check_slot(1, fb, "R2 R4 slot1 data padded");

        // R8: slot 0 full, passing frame lost
        mk_uni(fc, 20, 9);
        send(fc);
        check_lost("R8 lost count");
        check_slot(0, img0, "R8 slot0 unchanged");
        check_ctrl("R8 flags unchanged");

        // R3: mismatched unicast and short unicast rejected
        mk_uni(fx, 12, 2);
        fx[5] = 8'h56;
        send(fx);
        mk_uni(fx, 4, 2);
        send(fx);
        check_lost("R3 reject no loss");
        check_ctrl("R3 reject no flags");

        // R9: release slot 0
        wr('h17FC, 32'h8);
        check_ctrl("R9 release");
        mk_uni(fx, 10, 4);
        send(fx);
        check_ctrl("R7 slot0 refilled");
        rd('h17FC, d, dn);
        check(dn[0] === 1'b1, "R7 np reuses slot0", dn, 32'h1);
        rd('h1FFC, d, dn);
        check(dn === 32'h8, "R7 np slot1 idle", dn, 32'h8);

        // R6: no irq when the global enable is off, or when the slot enable is off
        irq_global_en = 1'b0;
        wr('h1FFC, 32'h8);
        mk_grp(fx, 9, 6);
        send(fx);
        irq_global_en = 1'b1;
        wr('h17FC, 32'h0);
        mk_grp(fx, 9, 7);
        send(fx);
        check_ctrl("R6 stores without irq");

        // R10: truncation into slot 1
        wr('h1FFC, 32'h8);
        mk_grp(fx, 2050, 3);
        send(fx);
        check_ctrl("R10 long frame stored");
        check_slot(1, fx, "R10 truncated data");
        rd('h1FF8, d, dn);
        check(d === 32'h0, "R12 slot1 reserved word", d, 32'h0);

        // R11: saturate loss counter
        wr('h17FC, 32'h1);
        wr('h1FFC, 32'h1);
        fx = {8'h01};
        for (int i = 0; i < 260; i++) send(fx);
        check_lost("R11 saturated");

        // R12: address map, latency, read-only data
        rd('h0004, d, dn);
        check(d === 32'h0, "R12 below window", d, 32'h0);
        rd('h1001, d, dn);
        check(d === 32'h0, "R12 unaligned", d, 32'h0);
        wr('h1000, 32'hDEADBEEF);
        check_slot(0, img0, "R12 data write ignored");

        finish_run();
    end
endmodule